// File: doc/BRIEF.md
# Synchronous Burst SRAM with Dual Address Strobes

This block is a synthesizable model of a single-port synchronous SRAM with a shared data path. The data path is split into byte lanes (four lanes of eight bits by default). Every control input is sampled on the rising clock edge. Two address strobes can open an access, and they have a fixed priority. The processor strobe always opens a read; a write can follow on the next edge. The controller strobe opens a read or a write in the same edge, depending on the write controls sampled with it.

After an access has been opened, edges with no strobe continue it. The burst-advance input steps a two-bit offset within a four-word group, in linear or interleaved order. The write controls on such an edge turn it into a write at the current burst address. Read data appears in the cycle after the edge that addressed it (flow-through timing). The bus-drive output is gated by an asynchronous output enable. It is forced off after a write, and during the first read cycle that follows a deselected state.

Top module: `burst_sram_ctrl`

## Requirements
- R1: An edge opens a selected access only when `sel_a_n_i`=0, `sel_b_i`=1 and `sel_c_n_i`=0. An opening edge with any other select pattern deselects the block: nothing is written, `rdata_drive_o` is 0 in the following cycle, and later edges with no strobe do nothing. Edges with no strobe leave the selection state unchanged.
- R2: If both strobes are low on an edge with `sel_a_n_i`=0, only the processor strobe acts, and that access is a read. If `sel_a_n_i`=1, the processor strobe is ignored. A controller strobe on that same edge is also ignored, and the edge behaves as an edge with no strobe.
- R3: On an edge where the processor strobe acts, the write controls are ignored and a read of `addr_i` is made. A write happens at the next edge only if the write controls request one there. That write goes to the captured address, with `wdata_i` from that next edge.
- R4: On an edge where the controller strobe acts (with the processor strobe high), a write request on that edge writes `wdata_i` to `addr_i` at once. With no write request, the edge reads `addr_i`.
- R5: The write lane mask is defined as follows. If `all_wr_n_i`=0, all lanes are written. Otherwise, lane k (bits 8k+7..8k) is written only when `lane_wr_en_n_i`=0 and `lane_sel_n_i[k]`=0. Lane selects without `lane_wr_en_n_i` low write nothing, and the edge is a read.
- R6: After any edge that performs a write, full or partial, `rdata_drive_o` is 0 in the following cycle, whatever the value of `out_en_n_i`.
- R7: After an edge that reads address X, `rdata_o` holds the word at X during the following cycle. In that cycle `rdata_drive_o` equals the inverse of `out_en_n_i`, which acts asynchronously.
- R8: A read opened while the block was deselected (including right after reset) keeps `rdata_drive_o` at 0 for its first cycle. The next edge with no strobe and `burst_adv_n_i`=1 reads the same address again, and that read drives the bus.
- R9: On an edge with no strobe while selected, `burst_adv_n_i`=0 advances a two-bit step counter n, which is cleared when an access opens. The low two address bits become base+n mod 4 when `ilv_order_i`=0, and base XOR n when `ilv_order_i`=1. The upper address bits stay unchanged. With `burst_adv_n_i`=1, the address is held.
- R10: An edge with no strobe while selected, and with the write controls requesting a write, writes `wdata_i` at the current burst address. That address is already advanced when `burst_adv_n_i`=0.
- R11: A synchronous active-high `rst` clears the selection and read-valid state, so `rdata_drive_o` is 0 after the reset edge. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address captured by an opening strobe |
| sel_a_n_i | input | 1 | Select, active low; also qualifies the processor strobe |
| sel_b_i | input | 1 | Select, active high |
| sel_c_n_i | input | 1 | Select, active low |
| proc_strb_n_i | input | 1 | Processor address strobe, active low, highest priority |
| ctrl_strb_n_i | input | 1 | Controller address strobe, active low |
| burst_adv_n_i | input | 1 | Burst advance, active low |
| all_wr_n_i | input | 1 | Write all lanes, active low |
| lane_wr_en_n_i | input | 1 | Lane write enable, active low |
| lane_sel_n_i | input | LANES | Per-lane write selects, active low |
| ilv_order_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| out_en_n_i | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data |
| rdata_drive_o | output | 1 | Bus drive enable for the read data |

## Verification
The bench targets four cases:
- **Processor start with write controls low.** A design that honoured the write controls on that edge would corrupt the word. The bench reads the old word back in the next cycle to catch this.
- **Both strobes low, and a processor strobe with the first select high.** The bench also holds the second select low on the latter edge. A design that let the controller strobe act there would deselect itself and stop driving the bus.
- **Burst offsets in both orders across the wrap.** A design that mixed up add and XOR, or carried into the upper address bits, would return the wrong words.
- **Masking of the first read after a deselect or a reset, and the forced bus-off after lane writes.** A wrong design would drive the bus one cycle early, or while write data is present.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

  // Two-bit burst position: base plus step (linear) or base xor step (interleaved)
  function automatic logic [1:0] burst_offset(input logic [1:0] base,
                                              input logic [1:0] step,
                                              input logic       ilv);
    return ilv ? (base ^ step) : (base + step);
  endfunction

endpackage

// File: rtl/sram_cycle_decode.sv
`timescale 1ns/1ps
module sram_cycle_decode
  import burst_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel_a_n_i,
  input  logic             sel_b_i,
  input  logic             sel_c_n_i,
  input  logic             proc_strb_n_i,
  input  logic             ctrl_strb_n_i,
  input  logic             burst_adv_n_i,
  input  logic             all_wr_n_i,
  input  logic             lane_wr_en_n_i,
  input  logic [LANES-1:0] lane_sel_n_i,
  input  logic             sel_q,
  output logic             start,
  output logic             sel_in,
  output logic             load,
  output logic             advance,
  output sram_op_e         op,
  output logic [LANES-1:0] wr_mask
);

  logic proc_start;
  logic ctrl_start;
  logic wr_any;

  always_comb begin
    sel_in     = !sel_a_n_i && sel_b_i && !sel_c_n_i;
    proc_start = !proc_strb_n_i && !sel_a_n_i;
    // controller strobe only counts while the processor strobe is high
    ctrl_start = !ctrl_strb_n_i && proc_strb_n_i;
    start      = proc_start || ctrl_start;

    if (!all_wr_n_i)          wr_mask = '1;
    else if (!lane_wr_en_n_i) wr_mask = ~lane_sel_n_i;
    else                      wr_mask = '0;
    wr_any = |wr_mask;

    op      = OP_IDLE;
    load    = 1'b0;
    advance = 1'b0;
    if (start) begin
      if (sel_in) begin
        load = 1'b1;
        op   = (ctrl_start && wr_any) ? OP_WRITE : OP_READ;
      end
    end else if (sel_q) begin
      advance = !burst_adv_n_i;
      op      = wr_any ? OP_WRITE : OP_READ;
    end
  end

endmodule

// File: rtl/sram_burst_addr.sv
`timescale 1ns/1ps
module sram_burst_addr
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  input  logic              ilv_order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] eff_addr
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      base_q;
  logic [1:0]      cnt_q;
  logic [1:0]      step;

  always_comb begin
    step     = advance ? cnt_q + 2'd1 : cnt_q;
    eff_addr = load ? addr_i : {hi_q, burst_offset(base_q, step, ilv_order_i)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      hi_q   <= addr_i[ADDR_W-1:2];
      base_q <= addr_i[1:0];
      cnt_q  <= '0;
    end else if (advance) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  // R9: burst stepping never disturbs the upper address bits
  p_upper_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(hi_q));

  // R9: an opening strobe restarts the step count
  p_load_restart_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == 2'd0));

endmodule

// File: rtl/sram_lane_array.sv
`timescale 1ns/1ps
module sram_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic                    re,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we && wr_mask[l]) mem[addr] <= din[l*LANE_W +: LANE_W];
      if (re)               rd_q      <= mem[addr];
    end

    assign dout[l*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/burst_sram_ctrl.sv
`timescale 1ns/1ps
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    sel_a_n_i,
  input  logic                    sel_b_i,
  input  logic                    sel_c_n_i,
  input  logic                    proc_strb_n_i,
  input  logic                    ctrl_strb_n_i,
  input  logic                    burst_adv_n_i,
  input  logic                    all_wr_n_i,
  input  logic                    lane_wr_en_n_i,
  input  logic [LANES-1:0]        lane_sel_n_i,
  input  logic                    ilv_order_i,
  input  logic                    out_en_n_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rdata_drive_o
);

  localparam int DATA_W = LANES * LANE_W;

  logic              sel_q;
  logic              rd_vld_q;
  logic              mask_q;
  logic              start;
  logic              sel_in;
  logic              load;
  logic              advance;
  sram_op_e          op;
  logic [LANES-1:0]  wr_mask;
  logic [ADDR_W-1:0] eff_addr;
  logic              is_rd;
  logic              is_wr;
  logic [DATA_W-1:0] rd_word;

  sram_cycle_decode #(.LANES(LANES)) u_decode (
    .sel_a_n_i      (sel_a_n_i),
    .sel_b_i        (sel_b_i),
    .sel_c_n_i      (sel_c_n_i),
    .proc_strb_n_i  (proc_strb_n_i),
    .ctrl_strb_n_i  (ctrl_strb_n_i),
    .burst_adv_n_i  (burst_adv_n_i),
    .all_wr_n_i     (all_wr_n_i),
    .lane_wr_en_n_i (lane_wr_en_n_i),
    .lane_sel_n_i   (lane_sel_n_i),
    .sel_q          (sel_q),
    .start          (start),
    .sel_in         (sel_in),
    .load           (load),
    .advance        (advance),
    .op             (op),
    .wr_mask        (wr_mask)
  );

  sram_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .advance     (advance),
    .ilv_order_i (ilv_order_i),
    .addr_i      (addr_i),
    .eff_addr    (eff_addr)
  );

  assign is_rd = (op == OP_READ) && !rst;
  assign is_wr = (op == OP_WRITE) && !rst;

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .we      (is_wr),
    .re      (is_rd),
    .addr    (eff_addr),
    .wr_mask (wr_mask),
    .din     (wdata_i),
    .dout    (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= 1'b0;
      rd_vld_q <= 1'b0;
      mask_q   <= 1'b0;
    end else begin
      if (start) sel_q <= sel_in;
      rd_vld_q <= is_rd;
      // first read cycle out of a deselected state keeps the bus quiet
      mask_q   <= is_rd && !sel_q;
    end
  end

  assign rdata_o       = rd_word;
  assign rdata_drive_o = rd_vld_q && !mask_q && !out_en_n_i;

  // R6: a write edge is never followed by a driven bus
  p_write_quiets_bus_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WRITE) |=> !rdata_drive_o);

  // R8: a read opened from the deselected state is masked for one cycle
  p_first_read_masked_r8: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_READ) && !sel_q) |=> !rdata_drive_o);

  // R1: edges with no strobe keep the selection state
  p_idle_holds_sel_r1: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(sel_q));

  // R1: a deselecting strobe leaves the bus undriven
  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !sel_in) |=> !rdata_drive_o);

endmodule

// File: tb/burst_sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module burst_sram_ctrl_tb_top;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [2:0] CE_ON  = 3'b010; // {sel_a_n, sel_b, sel_c_n}
  localparam logic [2:0] CE_OFF = 3'b000; // sel_b low
  localparam logic [2:0] CE_A_HI = 3'b100; // sel_a_n high, sel_b low

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic          psn = 1'b1, csn = 1'b1, advn = 1'b1;
  logic          gwn = 1'b1, bwen = 1'b1;
  logic [3:0]    bwn = 4'hF;
  logic          ilv = 1'b0;
  logic          oen = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdrive;

  burst_sram_ctrl #(.ADDR_W(AW), .LANES(4), .LANE_W(8)) dut_i (
    .clk            (clk),
    .rst            (rst),
    .addr_i         (addr),
    .sel_a_n_i      (sel_a_n),
    .sel_b_i        (sel_b),
    .sel_c_n_i      (sel_c_n),
    .proc_strb_n_i  (psn),
    .ctrl_strb_n_i  (csn),
    .burst_adv_n_i  (advn),
    .all_wr_n_i     (gwn),
    .lane_wr_en_n_i (bwen),
    .lane_sel_n_i   (bwn),
    .ilv_order_i    (ilv),
    .out_en_n_i     (oen),
    .wdata_i        (wdata),
    .rdata_o        (rdata),
    .rdata_drive_o  (rdrive)
  );

  // scoreboard: one expected item per clock edge
  logic        q_eoe[$];
  logic        q_chkd[$];
  logic [31:0] q_ed[$];
  string       q_tag[$];
  int n_chk = 0;
  int n_bad = 0;

  task automatic push_exp(input logic eoe, input logic chkd, input logic [31:0] ed,
                          input string tag);
    q_eoe.push_back(eoe);
    q_chkd.push_back(chkd);
    q_ed.push_back(ed);
    q_tag.push_back(tag);
  endtask

  task automatic cyc(input logic [2:0] ce, input logic p_n, input logic c_n,
                     input logic adv_n, input logic gw_n, input logic bwe_n,
                     input logic [3:0] bw_n, input logic [AW-1:0] a,
                     input logic [31:0] d, input logic oe_n,
                     input logic eoe, input logic chkd, input logic [31:0] ed,
                     input string tag);
    @(negedge clk);
    rst = 1'b0;
    {sel_a_n, sel_b, sel_c_n} = ce;
    psn = p_n; csn = c_n; advn = adv_n;
    gwn = gw_n; bwen = bwe_n; bwn = bw_n;
    addr = a; wdata = d; oen = oe_n;
    push_exp(eoe, chkd, ed, tag);
  endtask

  task automatic ctl_wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    cyc(CE_ON, 1, 0, 1, 0, 1, 4'hF, a, d, 0, 0, 0, '0, tag);
  endtask

  task automatic ctl_rd(input logic [AW-1:0] a, input logic eoe, input logic [31:0] ed,
                        input string tag);
    cyc(CE_ON, 1, 0, 1, 1, 1, 4'hF, a, '0, 0, eoe, eoe, ed, tag);
  endtask

  task automatic nxt(input logic adv_n, input logic eoe, input logic [31:0] ed,
                     input string tag);
    cyc(CE_ON, 1, 1, adv_n, 1, 1, 4'hF, '0, '0, 0, eoe, eoe, ed, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    psn = 1'b1; csn = 1'b1; advn = 1'b1; gwn = 1'b1; bwen = 1'b1; bwn = 4'hF;
    push_exp(1'b0, 1'b0, '0, tag);
  endtask

  // monitor: compare away from the active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_eoe.size() > 0) begin
        logic        eoe;
        logic        chkd;
        logic [31:0] ed;
        string       tag;
        eoe  = q_eoe.pop_front();
        chkd = q_chkd.pop_front();
        ed   = q_ed.pop_front();
        tag  = q_tag.pop_front();
        n_chk++;
        if (rdrive !== eoe) begin
          n_bad++;
          $display("FAIL %s: rdata_drive_o=%b expected %b", tag, rdrive, eoe);
        end
        if (chkd) begin
          n_chk++;
          if (rdata !== ed) begin
            n_bad++;
            $display("FAIL %s: rdata_o=%h expected %h", tag, rdata, ed);
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1-all: run still active after %0d cycles, expected completion", 5000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset("R11 reset leaves bus undriven");
    ctl_wr(8'd5, 32'hA5A5_0005, "R4/R6 controller write with out_en low");
    ctl_wr(8'd6, 32'h1122_3344, "R4 controller write word 6");
    cyc(CE_ON, 1, 0, 1, 1, 0, 4'b1010, 8'd6, 32'hAABB_CCDD, 0, 0, 0, '0,
        "R5/R6 lane write lanes 0 and 2");
    cyc(CE_ON, 1, 0, 1, 1, 1, 4'b0000, 8'd6, 32'hFFFF_FFFF, 0, 1, 1, 32'h11BB_33DD,
        "R5/R7 lane selects without enable read back");
    cyc(CE_ON, 1, 1, 1, 1, 1, 4'hF, '0, '0, 1, 0, 0, '0, "R7 out_en high gates drive");
    cyc(CE_OFF, 1, 0, 1, 1, 1, 4'hF, 8'd5, '0, 0, 0, 0, '0, "R1 deselecting strobe");
    cyc(CE_OFF, 1, 0, 1, 0, 1, 4'hF, 8'd5, 32'hDEAD_BEEF, 0, 0, 0, '0,
        "R1 deselected write attempt");
    cyc(CE_ON, 0, 1, 1, 1, 1, 4'hF, 8'd5, '0, 0, 0, 0, '0, "R8 first read after deselect masked");
    nxt(1, 1, 32'hA5A5_0005, "R8/R1 held re-read drives unchanged word");

    ctl_wr(8'd9, 32'h1234_5678, "R4 seed word 9");
    cyc(CE_ON, 0, 1, 1, 0, 1, 4'hF, 8'd9, 32'hDEAD_0009, 0, 1, 1, 32'h1234_5678,
        "R3 write controls ignored on processor start");
    cyc(CE_ON, 1, 1, 1, 0, 1, 4'hF, '0, 32'h9999_0000, 0, 0, 0, '0,
        "R3/R6 processor write second edge");
    ctl_rd(8'd9, 1, 32'h9999_0000, "R3 processor write landed");

    cyc(CE_ON, 0, 0, 1, 0, 1, 4'hF, 8'd5, 32'hBAD0_0005, 0, 1, 1, 32'hA5A5_0005,
        "R2 both strobes processor wins as read");
    cyc(CE_A_HI, 0, 0, 1, 1, 1, 4'hF, 8'd9, '0, 0, 1, 1, 32'hA5A5_0005,
        "R2 strobes ignored with sel_a high");

    for (int i = 0; i < 4; i++) ctl_wr(8'h10 + 8'(i), 32'h100 + i, "R4 burst prefill");
    ctl_rd(8'h12, 1, 32'h102, "R7 burst start 0x12");
    nxt(0, 1, 32'h103, "R9 linear step 1");
    nxt(0, 1, 32'h100, "R9 linear wrap step 2");
    nxt(0, 1, 32'h101, "R9 linear step 3");
    nxt(1, 1, 32'h101, "R9 hold without advance");
    cyc(CE_OFF, 1, 0, 1, 1, 1, 4'hF, '0, '0, 0, 0, 0, '0, "R1 deselect before order change");
    ilv = 1'b1;
    ctl_rd(8'h11, 0, '0, "R8 masked start of interleaved burst");
    nxt(0, 1, 32'h100, "R9 interleaved step 1");
    nxt(0, 1, 32'h103, "R9 interleaved step 2");
    nxt(0, 1, 32'h102, "R9 interleaved step 3");

    ctl_wr(8'h20, 32'hA0A0_A0A0, "R4 burst write start");
    ilv = 1'b0;
    cyc(CE_ON, 1, 1, 0, 0, 1, 4'hF, '0, 32'hA1A1_A1A1, 0, 0, 0, '0, "R10 burst write step 1");
    cyc(CE_ON, 1, 1, 0, 0, 1, 4'hF, '0, 32'hA2A2_A2A2, 0, 0, 0, '0, "R10 burst write step 2");
    ctl_rd(8'h21, 1, 32'hA1A1_A1A1, "R10 burst word 0x21");
    ctl_rd(8'h22, 1, 32'hA2A2_A2A2, "R10 burst word 0x22");
    ctl_rd(8'h20, 1, 32'hA0A0_A0A0, "R10 burst word 0x20");

    do_reset("R11 mid-run reset quiets bus");
    nxt(1, 0, '0, "R11 no selection after reset");
    ctl_rd(8'd5, 0, '0, "R11/R8 first read after reset masked");
    nxt(1, 1, 32'hA5A5_0005, "R11 array contents kept");

    repeat (3) @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule